// File: doc/BRIEF.md
# Audio Capture Ring Buffer with Fill and Overrun Interrupts

This block stores incoming audio samples in an on-chip circular buffer while capture is switched on. A host drains the buffer through a small 16-bit register window. Each sample arrives right-justified on a 24-bit input. It is reduced to its 16 most significant valid bits according to a programmable sample width, and that word is stored. Reading the data register pops the oldest stored word. Two read-only registers report where the writer and the reader currently stand, as word indices.

Three event sources share a single interrupt line. A fill-level event fires when an accepted sample leaves the buffer holding a nonzero multiple of a selectable fraction (one eighth, one quarter or one half) of its depth. An overrun event fires when a sample arrives while the buffer is full. An external-device event follows a level input from a neighbouring device. Each source has a sticky status bit, cleared by reading the status register, and its own enable. A clear command in the control register resets both pointers and drops the buffered data.

Register reads return data on the cycle after the read strobe. The buffer holds 2^AW words.

Top module: `capbuf_top`

## Requirements
- R1: A sample strobe is stored only while control bit 0 (capture) is 1; while it is 0, strobes leave the write pointer and the buffer unchanged.
- R2: Control bits [3:2] select the sample width, and the stored word is: code 00 sample[15:0], 01 sample[17:2], 10 sample[19:4], 11 sample[23:8]. Reading control (index 3) returns {width code, 0, capture} in bits [3:0].
- R3: A read of index 0 returns the oldest stored word on the next cycle and advances the read pointer by one. On an empty buffer it returns 0 and the read pointer stays put.
- R4: Index 1 returns the write pointer and index 2 the read pointer, both as word indices modulo the depth, zero-extended.
- R5: A sample accepted by capture while 2^AW words are held is dropped (write pointer unchanged) and sets status bit 1.
- R6: Enable bits [1:0] of index 5 select the level step: 00 none, 01 depth/8, 10 depth/4, 11 depth/2. Status bit 0 sets when an accepted sample leaves the fill (write minus read, after that cycle's pop) at a nonzero multiple of the step.
- R7: Status bit 2 sets on every cycle in which the external event input is high.
- R8: A read of the status register (index 4) returns the bits [2:0] and then clears them. An event in the same cycle as the read sets its bit again.
- R9: The interrupt output is high when status bit 0 is set and the level code is nonzero, or bit 1 is set with enable bit 2, or bit 2 is set with enable bit 3. It reflects the register state after each clock edge.
- R10: Writing control with bit 1 set zeroes both pointers and status bits 0 and 1. Bit 1 reads back as 0.
- R11: After reset, the pointers, status, enables, control, read data and interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One sample is offered this cycle |
| smp_data | input | 24 | Right-justified sample |
| ext_evt | input | 1 | External-device event level |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Combined interrupt |

## Verification
A pointer that slips by one shows up as a wrong word on the very next data read. It also shows up in the pointer registers as soon as they are read, and in the level event, which then fires one sample early or late, so the interrupt line is compared after every cycle. A wrong full decision shows up within one buffer's worth of samples: either a word is overwritten and comes back wrong when popped, or the overrun bit is missing from the next status read. Status bits that do not clear, or that lose a same-cycle event, are exposed by the second of two back-to-back status reads.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [2:0] {
    REG_DATA  = 3'd0,
    REG_WPTR  = 3'd1,
    REG_RPTR  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_ISTAT = 3'd4,
    REG_IEN   = 3'd5
  } reg_idx_e;

  localparam int ST_LEVEL = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_EXT   = 2;
  localparam int NSRC     = 3;

  // keep the 16 most significant valid bits of a right-justified sample
  function automatic logic [15:0] pick_word(input logic [23:0] s, input logic [1:0] w);
    case (w)
      2'd0:    return s[15:0];
      2'd1:    return s[17:2];
      2'd2:    return s[19:4];
      default: return s[23:8];
    endcase
  endfunction
endpackage

// File: rtl/capbuf_mem.sv
module capbuf_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/capbuf_ptrs.sv
module capbuf_ptrs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [1:0]    lvl_code,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] rp,
  output logic [AW:0]   fill,
  output logic          empty,
  output logic          push_ok,
  output logic          lvl_evt,
  output logic          ovr_evt
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] M8 = (AW+1)'((DEPTH / 8) - 1);
  localparam logic [AW:0] M4 = (AW+1)'((DEPTH / 4) - 1);
  localparam logic [AW:0] M2 = (AW+1)'((DEPTH / 2) - 1);

  logic [AW:0] wp_q, rp_q, wp_n, rp_n, fill_n, step_m1;
  logic full, pop_ok;

  assign fill    = wp_q - rp_q;
  assign full    = (fill == FULL_CNT);
  assign empty   = (fill == '0);
  assign push_ok = push_req && !full && !clr;
  assign ovr_evt = push_req && full && !clr;
  assign pop_ok  = pop_req && !empty && !clr;
  assign wp_n    = wp_q + (AW+1)'(push_ok);
  assign rp_n    = rp_q + (AW+1)'(pop_ok);
  assign fill_n  = wp_n - rp_n;

  always_comb begin
    case (lvl_code)
      2'd1:    step_m1 = M8;
      2'd2:    step_m1 = M4;
      default: step_m1 = M2;
    endcase
  end

  assign lvl_evt = push_ok && (lvl_code != 2'd0) && ((fill_n & step_m1) == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
    end
  end

  assign wp = wp_q[AW-1:0];
  assign rp = rp_q[AW-1:0];
endmodule

// File: rtl/capbuf_host.sv
module capbuf_host
  import capbuf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [15:0]   reg_wdata,
  input  logic [AW-1:0] wp,
  input  logic [AW-1:0] rp,
  input  logic          empty,
  input  logic          lvl_evt,
  input  logic          ovr_evt,
  input  logic          ext_evt,
  output logic          cap_en,
  output logic [1:0]    fmt,
  output logic [1:0]    lvl_code,
  output logic          clr,
  output logic          pop_req,
  output logic [15:0]   reg_q,
  output logic          sel_mem,
  output logic          irq
);
  logic [NSRC-1:0] stat_q, stat_n, ev, en_n;
  logic            ovr_en, ext_en;
  logic [3:0]      ien_n;
  logic            rd_stat;

  assign clr     = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[1];
  assign pop_req = reg_rd && (reg_addr == REG_DATA);
  assign rd_stat = reg_rd && (reg_addr == REG_ISTAT);

  assign ev[ST_LEVEL] = lvl_evt;
  assign ev[ST_OVR]   = ovr_evt;
  assign ev[ST_EXT]   = ext_evt;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic kill;
      assign kill      = rd_stat || (clr && (i != ST_EXT));
      assign stat_n[i] = ev[i] || (stat_q[i] && !kill);
    end
  endgenerate

  assign ien_n = (reg_wr && reg_addr == REG_IEN) ? reg_wdata[3:0]
                                                 : {ext_en, ovr_en, lvl_code};
  assign en_n[ST_LEVEL] = |ien_n[1:0];
  assign en_n[ST_OVR]   = ien_n[2];
  assign en_n[ST_EXT]   = ien_n[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      cap_en   <= 1'b0;
      fmt      <= 2'd0;
      lvl_code <= 2'd0;
      ovr_en   <= 1'b0;
      ext_en   <= 1'b0;
      reg_q    <= '0;
      sel_mem  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      stat_q <= stat_n;
      {ext_en, ovr_en, lvl_code} <= ien_n;
      irq <= |(stat_n & en_n);
      if (reg_wr && reg_addr == REG_CTRL) begin
        cap_en <= reg_wdata[0];
        fmt    <= reg_wdata[3:2];
      end
      if (reg_rd) begin
        sel_mem <= (reg_addr == REG_DATA) && !empty;
        case (reg_addr)
          REG_WPTR:  reg_q <= 16'(wp);
          REG_RPTR:  reg_q <= 16'(rp);
          REG_CTRL:  reg_q <= {12'd0, fmt, 1'b0, cap_en};
          REG_ISTAT: reg_q <= {13'd0, stat_q};
          REG_IEN:   reg_q <= {12'd0, ext_en, ovr_en, lvl_code};
          default:   reg_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/capbuf_top.sv
module capbuf_top
  import capbuf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        smp_valid,
  input  logic [23:0] smp_data,
  input  logic        ext_evt,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;
  logic          empty, push_ok, lvl_evt, ovr_evt;
  logic          cap_en, clr, pop_req, sel_mem, push_req;
  logic [1:0]    fmt, lvl_code;
  logic [15:0]   reg_q, mem_q;

  assign push_req = smp_valid && cap_en;

  capbuf_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst(rst), .clr(clr), .push_req(push_req), .pop_req(pop_req),
    .lvl_code(lvl_code), .wp(wp), .rp(rp), .fill(fill), .empty(empty),
    .push_ok(push_ok), .lvl_evt(lvl_evt), .ovr_evt(ovr_evt)
  );

  capbuf_mem #(.AW(AW), .DW(16)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wp), .wdata(pick_word(smp_data, fmt)),
    .re(pop_req), .raddr(rp), .rdata(mem_q)
  );

  capbuf_host #(.AW(AW)) u_host (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .wp(wp), .rp(rp), .empty(empty), .lvl_evt(lvl_evt),
    .ovr_evt(ovr_evt), .ext_evt(ext_evt), .cap_en(cap_en), .fmt(fmt),
    .lvl_code(lvl_code), .clr(clr), .pop_req(pop_req), .reg_q(reg_q),
    .sel_mem(sel_mem), .irq(irq)
  );

  assign reg_rdata = sel_mem ? mem_q : reg_q;
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW:0]   fill,
  input logic [AW-1:0] wp,
  input logic [AW-1:0] rp,
  input logic          push_req,
  input logic          cap_en,
  input logic          clr,
  input logic          pop_req,
  input logic          irq
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(1 << AW);

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_CNT);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (push_req && fill == FULL_CNT && !clr) |=> $stable(wp));

  assert_capture_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !clr) |=> $stable(wp));

  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_req && fill == '0 && !clr) |=> $stable(rp));

  assert_clear_ptrs_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (wp == '0 && rp == '0));

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (!irq && wp == '0 && rp == '0));
endmodule

bind capbuf_top capbuf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .fill(fill), .wp(wp), .rp(rp), .push_req(push_req),
  .cap_en(cap_en), .clr(clr), .pop_req(pop_req), .irq(irq)
);

// File: tb/sim_capbuf_top.sv
module sim_capbuf_top;
  localparam int AW = 5;
  localparam int D  = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        ext_evt = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model of the block
  logic [15:0] mm [D];
  int          m_wp = 0, m_rp = 0;
  bit          m_cap = 0;
  bit [1:0]    m_fmt = 0;
  bit [2:0]    m_st = 0;
  bit [3:0]    m_en = 0;

  always #4 clk = ~clk;

  capbuf_top #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .ext_evt(ext_evt), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [15:0] exp_word(logic [23:0] s, bit [1:0] w);
    logic [23:0] sh;
    sh = s >> (w == 2'd3 ? 8 : 2 * w);
    return sh[15:0];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [23:0] d, bit rd, bit wr, logic [2:0] a,
                      logic [15:0] wd, bit ext, string tag);
    int fill;
    logic [15:0] er;
    bit clr, acc, ev_l, ev_o;
    @(negedge clk);
    smp_valid = v; smp_data = d; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = wd; ext_evt = ext;
    @(posedge clk);
    #1;
    fill = m_wp - m_rp;
    case (a)
      3'd0: er = (fill > 0) ? mm[m_rp % D] : 16'h0;
      3'd1: er = 16'(m_wp % D);
      3'd2: er = 16'(m_rp % D);
      3'd3: er = {12'd0, m_fmt, 1'b0, m_cap};
      3'd4: er = {13'd0, m_st};
      3'd5: er = {12'd0, m_en};
      default: er = 16'h0;
    endcase
    clr = wr && a == 3'd3 && wd[1];
    acc = 0; ev_l = 0; ev_o = 0;
    if (!clr) begin
      if (v && m_cap && fill < D) begin
        mm[m_wp % D] = exp_word(d, m_fmt);
        m_wp++;
        acc = 1;
      end else if (v && m_cap) ev_o = 1;
      if (rd && a == 3'd0 && fill > 0) m_rp++;
      if (acc && m_en[1:0] != 0) begin
        int stp;
        stp = D >> (4 - m_en[1:0]);
        if (((m_wp - m_rp) % stp) == 0) ev_l = 1;
      end
    end
    if (rd && a == 3'd4) m_st = 0;
    if (clr) begin m_st[1:0] = 0; m_wp = 0; m_rp = 0; end
    m_st = m_st | {ext, ev_o, ev_l};
    if (wr && a == 3'd3) begin m_cap = wd[0]; m_fmt = wd[3:2]; end
    if (wr && a == 3'd5) m_en = wd[3:0];
    if (rd) chk(tag, reg_rdata, er);
    chk("R9 irq", {15'd0, irq},
        {15'd0, |(m_st & {m_en[3], m_en[2], |m_en[1:0]})});
  endtask

  task automatic rd_reg(logic [2:0] a, string tag);
    step(0, 0, 1, 0, a, 0, 0, tag);
  endtask
  task automatic wr_reg(logic [2:0] a, logic [15:0] wd, string tag);
    step(0, 0, 0, 1, a, wd, 0, tag);
  endtask
  task automatic push(logic [23:0] d, string tag);
    step(1, d, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state at the ports
    chk("R11 rdata", reg_rdata, 16'h0);
    chk("R11 irq", {15'd0, irq}, 16'h0);
    rd_reg(3'd1, "R11 wptr");
    rd_reg(3'd4, "R11 status");
    rd_reg(3'd5, "R11 enables");
    // R3: empty pop
    rd_reg(3'd0, "R3 empty data");
    rd_reg(3'd2, "R3 rptr after empty pop");
    // R1: capture off ignores samples
    for (int i = 0; i < 3; i++) push(24'h123456 + 24'(i), "R1");
    rd_reg(3'd1, "R1 wptr unchanged");
    // R2: each width code
    for (int f = 0; f < 4; f++) begin
      wr_reg(3'd3, 16'(f << 2) | 16'h1, "R2");
      rd_reg(3'd3, "R2 ctrl readback");
      push(24'hA5C3E1 ^ 24'(f * 24'h111111), "R2");
    end
    rd_reg(3'd1, "R4 wptr");
    for (int i = 0; i < 4; i++) rd_reg(3'd0, "R2 data word");
    rd_reg(3'd2, "R4 rptr");
    // R6: level steps, one eighth then one quarter
    wr_reg(3'd5, 16'h1, "R6");
    rd_reg(3'd4, "R8 clear");
    for (int i = 0; i < D / 8; i++) push(24'(i * 7), "R6");
    rd_reg(3'd4, "R6 eighth");
    wr_reg(3'd5, 16'h2, "R6");
    for (int i = 0; i < D / 8; i++) push(24'(i * 3), "R6");
    rd_reg(3'd4, "R6 quarter");
    wr_reg(3'd5, 16'h3, "R6");
    for (int i = 0; i < D / 4; i++) push(24'(i), "R6");
    rd_reg(3'd4, "R6 half");
    // R5: overrun
    wr_reg(3'd5, 16'h4, "R5");
    for (int i = 0; i < D; i++) push(24'(i * 5 + 1), "R5");
    rd_reg(3'd1, "R5 wptr at full");
    rd_reg(3'd4, "R5 overrun status");
    rd_reg(3'd0, "R5 oldest kept word");
    // R10: clear
    wr_reg(3'd3, 16'h3, "R10");
    rd_reg(3'd1, "R10 wptr");
    rd_reg(3'd2, "R10 rptr");
    rd_reg(3'd3, "R10 ctrl clear bit reads 0");
    rd_reg(3'd4, "R10 status");
    // R7/R8: external source, read clears, same-cycle event wins
    wr_reg(3'd5, 16'h8, "R7");
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    rd_reg(3'd4, "R7 ext status");
    rd_reg(3'd4, "R8 cleared");
    step(0, 0, 1, 0, 3'd4, 0, 1, "R8 read with event");
    rd_reg(3'd4, "R8 event kept");
    // random traffic
    for (int n = 0; n < 6000; n++) begin
      int op;
      bit v, e;
      op = $urandom % 12;
      v = ($urandom % 10) < 6;
      e = ($urandom % 20) == 0;
      if (op < 3)       step(v, 24'($urandom), 1, 0, 3'd0, 0, e, "R3 random");
      else if (op == 3) step(v, 24'($urandom), 1, 0, 3'($urandom % 6), 0, e, "R4 random");
      else if (op == 4) step(v, 24'($urandom), 0, 1, 3'd5, 16'($urandom), e, "R6 random");
      else if (op == 5) step(v, 24'($urandom), 0, 1, 3'd3,
                             {12'd0, 2'($urandom), (($urandom % 8) == 0), 1'b1}, e, "R10 random");
      else              step(v, 24'($urandom), 0, 0, 3'd0, 0, e, "R1 random");
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule